// File: doc/BRIEF.md
# Sequential Stream Buffer Prefetcher

This block is a small prefetch queue placed next to a cache. A lookup that misses both the cache and the buffer restarts the queue at the line following the missing one. The queue then asks memory for that many consecutive lines. Prefetched lines stay in the queue and are never written into the cache, so a wrong guess cannot evict useful cache contents. The cache has no fill path from this block. The only way out is the hit port.

Every lookup is compared with the oldest entry of the queue in the same cycle the cache is searched. When the oldest entry matches and its data has arrived, the line is returned at once and the entry is freed. The freed slot is then reloaded with the line just past the youngest queued address, so the queue keeps running one window ahead of the requester. When the oldest entry matches but its data is still in flight, the requester is told to wait rather than raise a new miss.

Memory requests carry the slot index as a tag, and responses may return in any order. Each slot has at most one request in flight. After a restart, a slot whose old request has not returned stays blocked until that response comes back. The response is then dropped.

Top module: `stream_prefetch`

## Requirements
- R1: While reset is active and in the first cycle after it, pf_hit_o, pf_stall_o and mreq_valid_o are low.
- R2: A lookup that misses the cache at line address A, and whose address differs from the head entry (or finds the buffer empty), restarts the buffer. Slot k then holds A+1+k, and requests for A+1 through A+DEPTH leave in that order with mreq_tag_o equal to 0 through DEPTH-1.
- R3: A lookup with lkp_cache_hit_i high produces neither a hit nor a stall, and it leaves the buffer unchanged, so a following cache-missing lookup of the head line still hits.
- R4: A cache-missing lookup that matches the head entry after its data has arrived raises pf_hit_o in the same cycle, with pf_data_o equal to the data returned for that line.
- R5: Consuming the head reloads that slot with the line one past the youngest queued address. That slot then issues one request, tagged with the slot index.
- R6: A cache-missing lookup that matches the head entry before its data has arrived raises pf_stall_o, does not restart the buffer, and hits once the data has arrived.
- R7: A response fills the slot named by mrsp_tag_i, whatever order responses come back in.
- R8: A slot never has more than one request in flight. After a restart, a slot with an old request in flight is not requested again until that response returns. That stale response is discarded and does not make the new line ready.
- R9: Only the head entry is searched. A lookup that matches a younger queued line is treated as a buffer miss and restarts the buffer.
- R10: While mreq_valid_o is high and mreq_ready_i is low, the request (valid, address and tag) holds unchanged into the next cycle unless a restart occurs in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lkp_valid_i | input | 1 | Cache lookup this cycle |
| lkp_addr_i | input | AW | Line address of the lookup |
| lkp_cache_hit_i | input | 1 | The cache itself hit this lookup |
| pf_hit_o | output | 1 | Buffer head supplies the line this cycle |
| pf_stall_o | output | 1 | Head matches, data not yet arrived; requester waits |
| pf_data_o | output | DW | Line data of the head entry |
| mreq_valid_o | output | 1 | Memory request valid |
| mreq_ready_i | input | 1 | Memory accepts the request |
| mreq_addr_o | output | AW | Requested line address |
| mreq_tag_o | output | IW | Slot index carried with the request |
| mrsp_valid_i | input | 1 | Memory response valid |
| mrsp_tag_i | input | IW | Slot index of the response |
| mrsp_data_i | input | DW | Response line data |

## Verification
The assertions check several rules on every cycle. Hit and stall never occur together. A cache hit never reaches the buffer outputs. A held request keeps its address and tag. A restart puts A+1 at the head. A slot is never issued twice while busy, and a stale response never marks a slot ready. The bench scenarios cover the rest. These are the ordering of the restart requests, the refill address after each pop, and data landing in the right slot when responses come back out of order. They also show that a stale response is dropped and its slot re-requested, and that a stall turns into a hit without a restart.

// File: rtl/sb_pkg.sv
package sb_pkg;
  typedef struct packed {
    logic valid;   // slot holds a queued line
    logic ready;   // data for that line has arrived
    logic issued;  // request for the current line has been sent
    logic busy;    // some request for this slot is in flight
  } sb_flags_t;
endpackage

// File: rtl/sb_entry.sv
module sb_entry
  import sb_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] load_addr_i,
  input  logic          issue_i,
  input  logic          rsp_i,
  input  logic [DW-1:0] rsp_data_i,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o,
  output sb_flags_t     flags_o
);
  sb_flags_t     flags_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      if (rsp_i)   flags_q.busy <= 1'b0;
      if (issue_i) flags_q.busy <= 1'b1;
      if (load_i) begin
        flags_q.valid  <= 1'b1;
        flags_q.ready  <= 1'b0;
        flags_q.issued <= 1'b0;
        addr_q         <= load_addr_i;
      end else begin
        if (issue_i) flags_q.issued <= 1'b1;
        // a response for an overwritten line is dropped
        if (rsp_i && flags_q.issued) begin
          flags_q.ready <= 1'b1;
          data_q        <= rsp_data_i;
        end
      end
    end
  end

  assign addr_o  = addr_q;
  assign data_o  = data_q;
  assign flags_o = flags_q;

  p_one_outstanding_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i |-> !flags_q.busy);

  p_stale_dropped_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_i && !flags_q.issued && !flags_q.ready) |=> !flags_q.ready);
endmodule

// File: rtl/sb_pick.sv
module sb_pick #(
  parameter  int DEPTH = 4,
  localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [IW-1:0]    head_i,
  input  logic [DEPTH-1:0] cand_i,
  output logic             found_o,
  output logic [IW-1:0]    idx_o
);
  // oldest candidate first, walking from the head
  always_comb begin
    int j;
    found_o = 1'b0;
    idx_o   = '0;
    for (int k = 0; k < DEPTH; k++) begin
      j = int'(head_i) + k;
      if (j >= DEPTH) j = j - DEPTH;
      if (!found_o && cand_i[j]) begin
        found_o = 1'b1;
        idx_o   = IW'(j);
      end
    end
  end
endmodule

// File: rtl/stream_prefetch.sv
module stream_prefetch
  import sb_pkg::*;
#(
  parameter  int AW    = 32,
  parameter  int DW    = 64,
  parameter  int DEPTH = 4,
  localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          lkp_valid_i,
  input  logic [AW-1:0] lkp_addr_i,
  input  logic          lkp_cache_hit_i,
  output logic          pf_hit_o,
  output logic          pf_stall_o,
  output logic [DW-1:0] pf_data_o,
  output logic          mreq_valid_o,
  input  logic          mreq_ready_i,
  output logic [AW-1:0] mreq_addr_o,
  output logic [IW-1:0] mreq_tag_o,
  input  logic          mrsp_valid_i,
  input  logic [IW-1:0] mrsp_tag_i,
  input  logic [DW-1:0] mrsp_data_i
);
  localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

  logic [AW-1:0]    slot_addr [DEPTH];
  logic [DW-1:0]    slot_data [DEPTH];
  sb_flags_t        slot_flags[DEPTH];
  logic [DEPTH-1:0] cand;

  logic [IW-1:0] head_q, lock_idx_q, pick_idx, sel_idx;
  logic [AW-1:0] next_q, head_addr;
  logic          lock_q, pick_found;
  sb_flags_t     head_flags;
  logic          miss, head_match, flush, pop, fire;

  assign head_addr  = slot_addr[head_q];
  assign head_flags = slot_flags[head_q];
  assign head_match = head_flags.valid && (head_addr == lkp_addr_i);
  assign miss       = lkp_valid_i && !lkp_cache_hit_i;
  assign pf_hit_o   = miss && head_match && head_flags.ready;
  assign pf_stall_o = miss && head_match && !head_flags.ready;
  assign pf_data_o  = slot_data[head_q];
  assign flush      = miss && !head_match;
  assign pop        = pf_hit_o;

  sb_pick #(.DEPTH(DEPTH)) u_pick (
    .head_i  (head_q),
    .cand_i  (cand),
    .found_o (pick_found),
    .idx_o   (pick_idx)
  );

  // a request left waiting keeps its slot until accepted
  assign sel_idx      = lock_q ? lock_idx_q : pick_idx;
  assign mreq_valid_o = lock_q || pick_found;
  assign mreq_addr_o  = slot_addr[sel_idx];
  assign mreq_tag_o   = sel_idx;
  assign fire         = mreq_valid_o && mreq_ready_i;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic          load, issue, rsp;
    logic [AW-1:0] load_addr;

    assign load      = flush || (pop && head_q == IW'(i));
    assign load_addr = flush ? lkp_addr_i + AW'(i + 1) : next_q;
    assign issue     = fire && sel_idx == IW'(i);
    assign rsp       = mrsp_valid_i && mrsp_tag_i == IW'(i);
    assign cand[i]   = slot_flags[i].valid && !slot_flags[i].issued && !slot_flags[i].busy;

    sb_entry #(.AW(AW), .DW(DW)) u_entry (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .load_i      (load),
      .load_addr_i (load_addr),
      .issue_i     (issue),
      .rsp_i       (rsp),
      .rsp_data_i  (mrsp_data_i),
      .addr_o      (slot_addr[i]),
      .data_o      (slot_data[i]),
      .flags_o     (slot_flags[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q     <= '0;
      next_q     <= '0;
      lock_q     <= 1'b0;
      lock_idx_q <= '0;
    end else begin
      if (flush) begin
        head_q <= '0;
        next_q <= lkp_addr_i + AW'(DEPTH + 1);
      end else if (pop) begin
        head_q <= (head_q == LAST) ? '0 : head_q + 1'b1;
        next_q <= next_q + 1'b1;
      end
      lock_q     <= mreq_valid_o && !mreq_ready_i && !flush;
      lock_idx_q <= sel_idx;
    end
  end

  p_hit_stall_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pf_hit_o && pf_stall_o));

  p_cache_hit_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lkp_valid_i && lkp_cache_hit_i) |-> (!pf_hit_o && !pf_stall_o));

  p_req_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mreq_valid_o && !mreq_ready_i && !flush) |=>
      (mreq_valid_o && $stable(mreq_addr_o) && $stable(mreq_tag_o)));

  p_restart_head_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush |=> (head_flags.valid && head_addr == $past(lkp_addr_i) + AW'(1)));
endmodule

// File: tb/stream_prefetch_tb.sv
module stream_prefetch_tb;
  localparam int AW = 32, DW = 64, DEPTH = 4, IW = 2;

  typedef struct packed {
    logic [AW-1:0] addr;
    logic          chit;
    logic          hit;
    logic          stall;
  } vec_t;

  // steady streaming after a restart at 0x100, all slots filled
  localparam vec_t VEC [12] = '{
    '{32'h101, 1'b0, 1'b1, 1'b0},  // R4
    '{32'h102, 1'b0, 1'b1, 1'b0},  // R4
    '{32'h103, 1'b1, 1'b0, 1'b0},  // R3 cache hit on head line
    '{32'h103, 1'b0, 1'b1, 1'b0},  // R3 head untouched
    '{32'h104, 1'b0, 1'b1, 1'b0},
    '{32'h105, 1'b0, 1'b1, 1'b0},  // R5 refilled line
    '{32'h106, 1'b0, 1'b1, 1'b0},  // R5
    '{32'h108, 1'b0, 1'b0, 1'b0},  // R9 younger line: restart
    '{32'h109, 1'b0, 1'b0, 1'b1},  // R6 data in flight
    '{32'h109, 1'b0, 1'b0, 1'b1},  // R6
    '{32'h109, 1'b0, 1'b1, 1'b0},  // R6 hit after arrival
    '{32'h10A, 1'b0, 1'b1, 1'b0}
  };

  logic          clk, rst_n;
  logic          lkp_valid, lkp_chit;
  logic [AW-1:0] lkp_addr;
  logic          pf_hit, pf_stall, mreq_valid, mreq_ready, mrsp_valid;
  logic [DW-1:0] pf_data, mrsp_data;
  logic [AW-1:0] mreq_addr;
  logic [IW-1:0] mreq_tag, mrsp_tag;

  stream_prefetch #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .lkp_valid_i(lkp_valid), .lkp_addr_i(lkp_addr), .lkp_cache_hit_i(lkp_chit),
    .pf_hit_o(pf_hit), .pf_stall_o(pf_stall), .pf_data_o(pf_data),
    .mreq_valid_o(mreq_valid), .mreq_ready_i(mreq_ready),
    .mreq_addr_o(mreq_addr), .mreq_tag_o(mreq_tag),
    .mrsp_valid_i(mrsp_valid), .mrsp_tag_i(mrsp_tag), .mrsp_data_i(mrsp_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_chk = 0, n_err = 0;
  bit done = 0, auto_en = 0;
  logic mem_rdy = 1'b0;
  int            q_tag[$];
  logic [AW-1:0] q_addr[$];
  logic          s_hit, s_stall, s_mv;
  logic [DW-1:0] s_data;
  logic [AW-1:0] s_ma;
  logic [IW-1:0] s_mt;

  function automatic logic [DW-1:0] data_of(input logic [AW-1:0] a);
    return {a, ~a};
  endfunction

  task automatic check(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic lv, input logic [AW-1:0] la, input logic ch,
                      input logic rv = 1'b0, input logic [IW-1:0] rt = '0,
                      input logic [DW-1:0] rd = '0);
    bit gone;
    @(negedge clk);
    lkp_valid  = lv;
    lkp_addr   = la;
    lkp_chit   = ch;
    mreq_ready = mem_rdy;
    mrsp_valid = 1'b0;
    if (rv) begin
      mrsp_valid = 1'b1; mrsp_tag = rt; mrsp_data = rd;
      gone = 0;
      for (int k = 0; k < q_tag.size(); k++) begin
        if (!gone && q_tag[k] == int'(rt)) begin
          q_tag.delete(k); q_addr.delete(k); gone = 1;
        end
      end
    end else if (auto_en && q_tag.size() > 0) begin
      mrsp_valid = 1'b1;
      mrsp_tag   = IW'(q_tag.pop_front());
      mrsp_data  = data_of(q_addr.pop_front());
    end
    #1;
    s_hit = pf_hit; s_stall = pf_stall; s_data = pf_data;
    s_mv = mreq_valid; s_ma = mreq_addr; s_mt = mreq_tag;
    if (mreq_valid && mem_rdy) begin
      q_tag.push_back(int'(mreq_tag));
      q_addr.push_back(mreq_addr);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; lkp_valid = 0; lkp_addr = '0; lkp_chit = 0;
    mreq_ready = 0; mrsp_valid = 0; mrsp_tag = '0; mrsp_data = '0;
    repeat (3) @(negedge clk);
    #1;
    check(pf_hit, 0, "R1 hit in reset");
    check(pf_stall, 0, "R1 stall in reset");
    check(mreq_valid, 0, "R1 req in reset");
    @(negedge clk); rst_n = 1'b1;
    step(0, '0, 0);
    check(s_mv, 0, "R1 req after reset");

    // R2: restart from empty, requests in order
    mem_rdy = 1'b1;
    step(1, 32'h400, 0);
    check({s_hit, s_stall}, 2'b00, "R2 empty buffer miss");
    for (int k = 0; k < DEPTH; k++) begin
      step(0, '0, 0);
      check({s_mv, s_ma, s_mt}, {1'b1, 32'h401 + AW'(k), IW'(k)}, "R2 request order");
    end
    step(0, '0, 0);
    check(s_mv, 0, "R8 no second request per slot");

    // R7: out-of-order responses
    mem_rdy = 1'b0;
    step(0, '0, 0, 1, 2'd2, data_of(32'h403));
    step(0, '0, 0, 1, 2'd0, data_of(32'h401));
    step(0, '0, 0, 1, 2'd3, data_of(32'h404));
    step(0, '0, 0, 1, 2'd1, data_of(32'h402));
    step(1, 32'h401, 0);
    check({s_hit, s_stall}, 2'b10, "R4 head hit");
    check(s_data, data_of(32'h401), "R7 data slot0");

    // R5: refill request, R10: held while not ready
    step(0, '0, 0);
    check({s_mv, s_ma, s_mt}, {1'b1, 32'h405, 2'd0}, "R5 refill request");
    step(0, '0, 0);
    check({s_mv, s_ma, s_mt}, {1'b1, 32'h405, 2'd0}, "R10 request held");
    mem_rdy = 1'b1;
    step(0, '0, 0);
    mem_rdy = 1'b0;
    step(1, 32'h402, 0);
    check(s_data, data_of(32'h402), "R7 data slot1");
    check(s_hit, 1, "R7 hit slot1");
    step(1, 32'h403, 0);
    check(s_data, data_of(32'h403), "R7 data slot2");

    // R8: restart with slot0 request still in flight
    step(1, 32'h800, 0);
    check({s_hit, s_stall}, 2'b00, "R8 restart miss");
    mem_rdy = 1'b1;
    for (int k = 1; k < DEPTH; k++) begin
      step(0, '0, 0);
      check({s_mv, s_ma, s_mt}, {1'b1, 32'h801 + AW'(k), IW'(k)}, "R8 busy slot skipped");
    end
    step(0, '0, 0);
    check(s_mv, 0, "R8 busy slot not reissued");
    step(0, '0, 0, 1, 2'd0, data_of(32'h405));
    step(1, 32'h801, 0);
    check({s_hit, s_stall}, 2'b01, "R8 stale data dropped");
    check({s_mv, s_ma, s_mt}, {1'b1, 32'h801, 2'd0}, "R8 reissue after stale");
    step(0, '0, 0, 1, 2'd0, data_of(32'h801));
    step(1, 32'h801, 0);
    check({s_hit, s_stall}, 2'b10, "R8 hit after reissue");
    check(s_data, data_of(32'h801), "R8 fresh data");

    // vector walk with the automatic memory
    auto_en = 1;
    repeat (8) step(0, '0, 0);
    step(1, 32'h100, 0);
    repeat (10) step(0, '0, 0);
    foreach (VEC[i]) begin
      step(1, VEC[i].addr, VEC[i].chit);
      check({s_hit, s_stall}, {VEC[i].hit, VEC[i].stall}, $sformatf("R4/R6/R9 vector %0d", i));
      if (VEC[i].hit) check(s_data, data_of(VEC[i].addr), $sformatf("R7 vector %0d data", i));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule